// File: doc/BRIEF.md
# AES-128 Round-Key Schedule Generator

This block turns a 128-bit cipher key into the full AES-128 key schedule: eleven 128-bit round keys, or 44 words of 32 bits. A synchronous reset captures the key as the first four words. After that, a small internal sequencer derives one further word on every clock until the whole schedule exists. The finished schedule is presented as one flat bus that a round-key selector can slice.

The same schedule serves both encryption and decryption. Only the order in which a consumer picks round keys differs, and that choice is made outside this block. Raising reset again at any point, including in the middle of an expansion, throws the old schedule away and starts over from whatever key is present on the input.

Top module: `aes_kx_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block does three things. It loads key bits 127:96, 95:64, 63:32 and 31:0 into schedule words 0, 1, 2 and 3. It clears words 4 to 43 to zero. It drives `done` low.
- R2: Schedule word i is presented on `xkey_out[1407-32*i -: 32]`, so round key r occupies `xkey_out[1407-128*r -: 128]` and round key 0 equals the loaded key.
- R3: On the k-th rising edge after reset is released (k = 1..40), exactly word 3+k is written. Words already written keep their values, and words not yet written stay zero.
- R4: A word whose index i is not a multiple of 4 equals w[i-4] XOR w[i-1].
- R5: A word whose index i is a multiple of 4 is formed in three steps. First, w[i-1] is rotated left by one byte. Second, each byte passes through the AES S-box. The S-box takes the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapping to 0, and then applies the affine map with constant 0x63. Third, the result is XORed with w[i-4] and with a round constant in the top byte. For i/4 = 1..10 the round constant is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36.
- R6: `done` rises on the same edge that writes word 43, which is the 40th edge after reset release. It is low before that edge.
- R7: Once `done` is high it stays high and `xkey_out` holds its value until the next reset. Changes on `key_in` in that time have no effect.
- R8: `key_in` is sampled only while `rst` is high. Changes to it during expansion do not alter the schedule.
- R9: A reset asserted in the middle of an expansion discards the partial schedule. Expansion then restarts from the key present during that reset.
- R10: For key 2b7e151628aed2a6abf7158809cf4f3c, the final round key (`xkey_out[127:0]`) is d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the key and restarts expansion |
| key_in | input | 128 | Cipher key, big-endian word order |
| xkey_out | output | 1408 | Expanded schedule, word 0 in the top bits |
| done | output | 1 | High once all 44 words are present |

## Verification
The bench builds the block with its default of eleven round keys. That is the only size where the AES-128 round constants and the 40-step expansion apply, and it makes all 44 words and all ten round constants observable. Several keys are swept: all-zero, all-ones, arithmetic patterns and the reference key. For each key, the full 1408-bit bus is compared after every edge against a schedule that the bench derives from its own brute-force S-box, so each word is checked in the cycle it appears. Key changes during and after expansion, and a reset that interrupts expansion, are also exercised at the ports.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;

    localparam int BYTE_W         = 8;
    localparam int WORD_W         = 32;
    localparam int KEY_W          = 128;
    localparam int KEY_WORDS      = KEY_W / WORD_W;
    localparam int WORD_BYTES     = WORD_W / BYTE_W;
    localparam int RCON_MAX_STEPS = 32;

    localparam logic [7:0] GF_REDUCE = 8'h1B;
    localparam logic [7:0] AFFINE_C  = 8'h63;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        KX_RUN  = 1'b0,
        KX_DONE = 1'b1
    } kx_state_e;

    // Selects how the next word is formed.
    typedef struct packed {
        logic  use_sub;
        byte_t rcon;
    } kx_mix_t;

    function automatic byte_t gf_xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? GF_REDUCE : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // Inverse as a^254 by square-and-multiply; zero maps to zero.
    function automatic byte_t gf_inv(input byte_t a);
        byte_t res;
        byte_t base;
        logic [7:0] expo;
        res  = 8'h01;
        base = a;
        expo = 8'd254;
        for (int i = 0; i < BYTE_W; i++) begin
            if (expo[i]) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        return res;
    endfunction

    function automatic byte_t sbox_fwd(input byte_t a);
        byte_t b;
        b = gf_inv(a);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
                 ^ {b[3:0], b[7:4]} ^ AFFINE_C;
    endfunction

    // Round constant for round r >= 1: x^(r-1) in GF(2^8).
    function automatic byte_t rcon_of(input logic [31:0] r);
        byte_t v;
        v = 8'h01;
        for (int unsigned k = 1; k < RCON_MAX_STEPS; k++) begin
            if (k < r) v = gf_xtime(v);
        end
        return v;
    endfunction

endpackage

// File: rtl/kx_sbox.sv
module kx_sbox
    import aes_kx_pkg::*;
(
    input  byte_t din,
    output byte_t dout
);
    assign dout = sbox_fwd(din);
endmodule

// File: rtl/kx_subword.sv
module kx_subword
    import aes_kx_pkg::*;
(
    input  word_t din,
    output word_t dout
);
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        kx_sbox u_sbox (
            .din  (din[g*BYTE_W +: BYTE_W]),
            .dout (dout[g*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/kx_wordgen.sv
module kx_wordgen
    import aes_kx_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  word_t            w_prev,
    input  word_t            w_back,
    output word_t            w_new
);
    word_t       rotated;
    word_t       substituted;
    kx_mix_t     mix;
    logic [31:0] round_no;

    assign rotated  = {w_prev[WORD_W-BYTE_W-1:0], w_prev[WORD_W-1 -: BYTE_W]};
    assign round_no = {{(32-IDX_W){1'b0}}, idx} >> 2;

    kx_subword u_subword (
        .din  (rotated),
        .dout (substituted)
    );

    always_comb begin
        mix.use_sub = (idx[1:0] == 2'b00);
        mix.rcon    = rcon_of(round_no);
        if (mix.use_sub)
            w_new = w_back ^ substituted ^ {mix.rcon, {(WORD_W-BYTE_W){1'b0}}};
        else
            w_new = w_back ^ w_prev;
    end
endmodule

// File: rtl/kx_ctrl.sv
module kx_ctrl
    import aes_kx_pkg::*;
#(
    parameter int NW    = 44,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] FIRST = IDX_W'(KEY_WORDS);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(NW - 1);

    kx_state_e        state;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= KX_RUN;
            idx   <= FIRST;
        end else if (state == KX_RUN) begin
            if (idx == LAST) state <= KX_DONE;
            else             idx   <= idx + 1'b1;
        end
    end

    assign wr_en  = (state == KX_RUN);
    assign wr_idx = idx;
    assign done   = (state == KX_DONE);

    // R3: one new word per cycle while running
    p_idx_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (state == KX_RUN && idx != LAST) |=> (idx == $past(idx) + 1'b1));

    // R6: completion follows the last write
    p_done_after_last_r6: assert property (@(posedge clk) disable iff (rst)
        (state == KX_RUN && idx == LAST) |=> done);

    // R7: completion is sticky until reset
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
endmodule

// File: rtl/aes_kx_top.sv
module aes_kx_top
    import aes_kx_pkg::*;
#(
    parameter int NUM_ROUND_KEYS = 11
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [KEY_W-1:0]                      key_in,
    output logic [KEY_WORDS*NUM_ROUND_KEYS*WORD_W-1:0] xkey_out,
    output logic                                  done
);
    localparam int NW    = KEY_WORDS * NUM_ROUND_KEYS;
    localparam int XK_W  = NW * WORD_W;
    localparam int IDX_W = $clog2(NW);
    localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] BACK = IDX_W'(KEY_WORDS);

    word_t            sched [NW];
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    word_t            w_new;

    kx_ctrl #(.NW(NW), .IDX_W(IDX_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .done   (done)
    );

    kx_wordgen #(.IDX_W(IDX_W)) u_wordgen (
        .idx    (wr_idx),
        .w_prev (sched[wr_idx - ONE]),
        .w_back (sched[wr_idx - BACK]),
        .w_new  (w_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < KEY_WORDS; i++)
                sched[i] <= key_in[KEY_W-1-WORD_W*i -: WORD_W];
            for (int i = KEY_WORDS; i < NW; i++)
                sched[i] <= '0;
        end else if (wr_en) begin
            sched[wr_idx] <= w_new;
        end
    end

    for (genvar g = 0; g < NW; g++) begin : g_out
        assign xkey_out[XK_W-1-WORD_W*g -: WORD_W] = sched[g];
    end

    // R3: a slot is still empty when its turn comes
    p_slot_empty_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (sched[wr_idx] == '0));

    // R8: the captured key words never move during expansion
    p_key_words_hold_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(xkey_out[XK_W-1 -: KEY_W]));

    // R7: schedule frozen after completion
    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(xkey_out));
endmodule

// File: tb/aes_kx_top_test.sv
module aes_kx_top_test;
    localparam int NW   = 44;
    localparam int XK_W = NW * 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [127:0]      key_in = '0;
    logic [XK_W-1:0]   xkey_out;
    logic              done;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] mw [NW];

    always #10 clk = ~clk;

    aes_kx_top uut (
        .clk      (clk),
        .rst      (rst),
        .key_in   (key_in),
        .xkey_out (xkey_out),
        .done     (done)
    );

    function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] tb_sbox(input logic [7:0] a);
        logic [7:0] inv;
        logic [7:0] c;
        logic [7:0] r;
        inv = 8'h00;
        for (int v = 1; v < 256; v++)
            if (tb_mul(a, 8'(v)) == 8'h01) inv = 8'(v);
        c = 8'h63;
        for (int i = 0; i < 8; i++)
            r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
        return r;
    endfunction

    task automatic build_model(input logic [127:0] k);
        logic [7:0]  rc;
        logic [31:0] t;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) mw[i] = k[127-32*i -: 32];
        for (int i = 4; i < NW; i++) begin
            if (i % 4 == 0) begin
                t = {mw[i-1][23:0], mw[i-1][31:24]};
                t = {tb_sbox(t[31:24]), tb_sbox(t[23:16]), tb_sbox(t[15:8]), tb_sbox(t[7:0])};
                mw[i] = mw[i-4] ^ t ^ {rc, 24'h0};
                rc = rc[7] ? ((rc << 1) ^ 8'h1B) : (rc << 1);
            end else begin
                mw[i] = mw[i-4] ^ mw[i-1];
            end
        end
    endtask

    function automatic logic [XK_W-1:0] exp_bus(input int nwords);
        logic [XK_W-1:0] b;
        b = '0;
        for (int i = 0; i < NW; i++)
            if (i < nwords) b[XK_W-1-32*i -: 32] = mw[i];
        return b;
    endfunction

    task automatic chk_bus(input string req, input logic [XK_W-1:0] expv);
        n_chk++;
        if (xkey_out !== expv) begin
            n_fail++;
            $display("FAIL %s: xkey_out actual=%h expected=%h", req, xkey_out, expv);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: done actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic run_key(input logic [127:0] k, input bit restart, input logic [127:0] k2);
        logic [127:0] active;
        active = k;
        build_model(k);
        @(negedge clk);
        rst = 1'b1;
        key_in = k;
        @(negedge clk);
        chk_bit("R1", done, 1'b0);
        chk_bus("R1,R2", exp_bus(4));
        if (restart) begin
            rst = 1'b0;
            repeat (10) @(negedge clk);
            chk_bit("R9 pre", done, 1'b0);
            rst = 1'b1;
            key_in = k2;
            active = k2;
            build_model(k2);
            @(negedge clk);
            chk_bus("R9", exp_bus(4));
        end
        rst = 1'b0;
        for (int c = 1; c <= 40; c++) begin
            if (c == 7) key_in = ~active;
            @(negedge clk);
            if ((3 + c) % 4 == 0) chk_bus("R3,R5,R8", exp_bus(4 + c));
            else                  chk_bus("R3,R4,R8", exp_bus(4 + c));
            chk_bit("R6", done, (c == 40));
        end
        key_in = 128'h0;
        repeat (3) begin
            @(negedge clk);
            chk_bit("R7", done, 1'b1);
            chk_bus(restart ? "R9" : "R7", exp_bus(NW));
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog R6: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] ref_key;
        ref_key = 128'h2b7e151628aed2a6abf7158809cf4f3c;
        run_key(ref_key, 1'b0, '0);
        run_key('0, 1'b0, '0);
        run_key({128{1'b1}}, 1'b0, '0);
        for (int j = 1; j <= 3; j++) begin
            logic [31:0] s;
            s = 32'h9e3779b9 * 32'(j);
            run_key({s, s ^ 32'h01234567, ~s, s + 32'h0f0f0f0f}, 1'b0, '0);
        end
        run_key(128'h000102030405060708090a0b0c0d0e0f, 1'b1, ref_key);
        n_chk++;
        if (xkey_out[127:0] !== 128'hd014f9a8c9ee2589e13f0cc8b6630ca6) begin
            n_fail++;
            $display("FAIL R10: last round key actual=%h expected=%h",
                     xkey_out[127:0], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule